// File: doc/BRIEF.md
# Buffered Compare Timer

An up-counting timer with two compare values. The count clock is either the system clock divided by a selectable power of two or the rising edges of an external event pin, synchronised into the system clock domain. When the count reaches compare value A, the output pin goes high and an interrupt strobe fires. When it reaches compare value B, the output pin goes low, a second strobe fires and the counter restarts from zero. B therefore sets the period and A sets the duty.

Software reaches the block over a four-word register bus: control, compare A, compare B and a read-only count. With the buffer-select bit set, compare writes go to shadow registers. Those are copied into the active compare registers only when the counter restarts, on match B or on a software preset. This lets the period and duty change without a glitch.

Top module: `bcmp_timer`

## Requirements
- R1: After reset, the control word reads 0 (stopped, direct access, internal clock, divide select 000), the count reads 0, and `tmr_o`, `irq_a_o` and `irq_b_o` are low.
- R2: Control bits [6:4] select the internal divider: 000=/1, 001=/2, 010=/4, 011=/16, 100=/64, 101=/256, 110=/1024, 111=/4096. With A=0 and B=1, `irq_b_o` pulses every 2·div system clocks.
- R3: Control bit 3 (external source) and bits [6:4] change only on a control write made while run (bit 0) is 0. A write made while running leaves them unchanged, as a control readback shows.
- R4: Address 3 reads the count. It advances by one per count tick. A tick taken while the count equals B loads 0 instead, so the period is B+1 ticks.
- R5: `irq_a_o` / `irq_b_o` is a one-clock pulse in the clock after a tick taken while the count equals A / B.
- R6: `tmr_o` goes high on a match A and low on a match B. Match B wins when both occur together. `tmr_o` is forced low while run is 0.
- R7: With buffer select (bit 2) at 0, writes and reads at addresses 1 (A) and 2 (B) reach the active compare registers. With it at 1, they reach the shadow buffers.
- R8: With buffer select at 1, both buffers are copied into the active registers on the edge where the counter restarts, whether from match B or from a preset.
- R9: Writing 1 to control bit 1 forces the count to 0 on that edge without producing a match. The bit always reads back 0.
- R10: With bit 3 at 1, each rising edge of `evt_i` yields one tick, detected after two synchroniser flops. Events need at least two system clocks per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 compare A, 2 compare B, 3 count |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| evt_i | input | 1 | External event input |
| tmr_o | output | 1 | Timer output waveform |
| irq_a_o | output | 1 | Match A interrupt strobe |
| irq_b_o | output | 1 | Match B interrupt strobe |

## Verification
The assertions assume that compare A and B are written before the timer first runs, because their reset value is undefined. They also assume that a preset never arrives in the same cycle as a compare write, which holds because both share the one write strobe. The stimulus always stops the timer with a preset before it lowers B. This keeps the count below the new B, so no run has to wrap through the full 16-bit range. The event pin is toggled with at least one full system clock high and one low, which matches the minimum event period that the synchroniser assumes.

// File: rtl/bct_pkg.sv
package bct_pkg;
  localparam int PRE_W = 12;

  localparam int CTRL_RUN    = 0;
  localparam int CTRL_PRESET = 1;
  localparam int CTRL_BSEL   = 2;
  localparam int CTRL_EXT    = 3;
  localparam int CTRL_SEL    = 4;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CMPA = 2'd1,
    ADDR_CMPB = 2'd2,
    ADDR_CNT  = 2'd3
  } reg_addr_e;

  function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] sel);
    int sh;
    case (sel)
      3'd0: sh = 0;
      3'd1: sh = 1;
      3'd2: sh = 2;
      3'd3: sh = 4;
      3'd4: sh = 6;
      3'd5: sh = 8;
      3'd6: sh = 10;
      default: sh = 12;
    endcase
    div_mask = PRE_W'((1 << sh) - 1);
  endfunction
endpackage

// File: rtl/bct_tick_gen.sv
module bct_tick_gen
  import bct_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       ext_i,
  input  logic [2:0] sel_i,
  input  logic       evt_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [SYNC_N:0]  sync_q;
  logic [PRE_W-1:0] mask;
  logic             evt_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else if (run_i) pre_q <= pre_q + 1'b1;
    else pre_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else sync_q <= {sync_q[SYNC_N-1:0], evt_i};
  end

  assign mask     = div_mask(sel_i);
  assign evt_edge = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

  always_comb begin
    if (!run_i) tick_o = 1'b0;
    else if (ext_i) tick_o = evt_edge;
    else tick_o = ((pre_q & mask) == mask);
  end
endmodule

// File: rtl/bct_cmp_bank.sv
module bct_cmp_bank #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic [N-1:0] we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         bsel_i,
  input  logic         load_i,
  output logic [W-1:0] act_o [N],
  output logic [W-1:0] buf_o [N]
);
  // reset value intentionally undefined
  for (genvar ch = 0; ch < N; ch++) begin : g_ch
    logic [W-1:0] act_q, buf_q;

    always_ff @(posedge clk_i) begin
      if (we_i[ch] && !bsel_i) act_q <= wdata_i;
      else if (load_i) act_q <= buf_q;
      if (we_i[ch] && bsel_i) buf_q <= wdata_i;
    end

    assign act_o[ch] = act_q;
    assign buf_o[ch] = buf_q;
  end
endmodule

// File: rtl/bct_count_core.sv
module bct_count_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         preset_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic [W-1:0] cmp_b_i,
  output logic [W-1:0] cnt_o,
  output logic         restart_o,
  output logic         irq_a_o,
  output logic         irq_b_o,
  output logic         tmr_o
);
  logic [W-1:0] cnt_q;
  logic         hit_a, hit_b;
  logic         irq_a_q, irq_b_q, tmr_q;

  assign hit_a     = tick_i && !preset_i && (cnt_q == cmp_a_i);
  assign hit_b     = tick_i && !preset_i && (cnt_q == cmp_b_i);
  assign restart_o = preset_i || hit_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (restart_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_a_q <= 1'b0;
      irq_b_q <= 1'b0;
      tmr_q   <= 1'b0;
    end else begin
      irq_a_q <= hit_a;
      irq_b_q <= hit_b;
      if (!run_i) tmr_q <= 1'b0;
      else if (hit_b) tmr_q <= 1'b0;
      else if (hit_a) tmr_q <= 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign irq_a_o = irq_a_q;
  assign irq_b_o = irq_b_q;
  assign tmr_o   = tmr_q;
endmodule

// File: rtl/bcmp_timer.sv
module bcmp_timer
  import bct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             evt_i,
  output logic             tmr_o,
  output logic             irq_a_o,
  output logic             irq_b_o
);
  localparam int NCMP = 2;

  logic             run_q, bsel_q, ext_q;
  logic [2:0]       sel_q;
  logic             wr_ctrl, preset, tick, restart, load;
  logic [NCMP-1:0]  cmp_we;
  logic [CNT_W-1:0] act [NCMP];
  logic [CNT_W-1:0] bufr [NCMP];
  logic [CNT_W-1:0] cnt;

  assign wr_ctrl   = wr_i && (reg_addr_e'(addr_i) == ADDR_CTRL);
  assign preset    = wr_ctrl && wdata_i[CTRL_PRESET];
  assign cmp_we[0] = wr_i && (reg_addr_e'(addr_i) == ADDR_CMPA);
  assign cmp_we[1] = wr_i && (reg_addr_e'(addr_i) == ADDR_CMPB);
  assign load      = bsel_q && restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      bsel_q <= 1'b0;
      ext_q  <= 1'b0;
      sel_q  <= 3'd0;
    end else if (wr_ctrl) begin
      run_q  <= wdata_i[CTRL_RUN];
      bsel_q <= wdata_i[CTRL_BSEL];
      if (!run_q) begin
        ext_q <= wdata_i[CTRL_EXT];
        sel_q <= wdata_i[CTRL_SEL+:3];
      end
    end
  end

  bct_tick_gen #(.SYNC_N(SYNC_N)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .ext_i (ext_q),
    .sel_i (sel_q),
    .evt_i (evt_i),
    .tick_o(tick)
  );

  bct_cmp_bank #(.W(CNT_W), .N(NCMP)) u_cmp (
    .clk_i  (clk_i),
    .we_i   (cmp_we),
    .wdata_i(wdata_i),
    .bsel_i (bsel_q),
    .load_i (load),
    .act_o  (act),
    .buf_o  (bufr)
  );

  bct_count_core #(.W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .tick_i   (tick),
    .preset_i (preset),
    .cmp_a_i  (act[0]),
    .cmp_b_i  (act[1]),
    .cnt_o    (cnt),
    .restart_o(restart),
    .irq_a_o  (irq_a_o),
    .irq_b_o  (irq_b_o),
    .tmr_o    (tmr_o)
  );

  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      ADDR_CTRL: begin
        rdata_o[CTRL_RUN]     = run_q;
        rdata_o[CTRL_BSEL]    = bsel_q;
        rdata_o[CTRL_EXT]     = ext_q;
        rdata_o[CTRL_SEL+:3]  = sel_q;
      end
      ADDR_CMPA: rdata_o = bsel_q ? bufr[0] : act[0];
      ADDR_CMPB: rdata_o = bsel_q ? bufr[1] : act[1];
      default:   rdata_o = cnt;
    endcase
  end
endmodule

// File: rtl/bct_timer_chk.sv
module bct_timer_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run_i,
  input logic [2:0]   sel_i,
  input logic         bsel_i,
  input logic         preset_i,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] act_a_i,
  input logic [W-1:0] buf_a_i,
  input logic         tmr_i,
  input logic         irq_a_i,
  input logic         irq_b_i
);
  assert_stop_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !tmr_i);
  assert_b_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_b_i |-> !tmr_i);
  assert_a_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_a_i && !irq_b_i) |-> tmr_i);
  assert_b_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_b_i |-> (cnt_i == '0));
  assert_irq_needs_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_a_i || irq_b_i) |-> $past(run_i));
  assert_sel_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) |-> $stable(sel_i));
  assert_preset_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |=> (cnt_i == '0));
  assert_preset_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preset_i && bsel_i) |=> (act_a_i == $past(buf_a_i)));
endmodule

bind bcmp_timer bct_timer_chk #(.W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_q),
  .sel_i   (sel_q),
  .bsel_i  (bsel_q),
  .preset_i(preset),
  .cnt_i   (cnt),
  .act_a_i (act[0]),
  .buf_a_i (bufr[0]),
  .tmr_i   (tmr_o),
  .irq_a_i (irq_a_o),
  .irq_b_i (irq_b_o)
);

// File: tb/sim_bcmp_timer.sv
`timescale 1ns/1ps
module sim_bcmp_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = 16'd0;
  logic [15:0] rdata_o;
  logic        evt_i = 1'b0;
  logic        tmr_o, irq_a_o, irq_b_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;
  logic [1:0] rd_sel = 2'd0;

  always #10 clk_i = ~clk_i;

  bcmp_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i),
    .tmr_o(tmr_o), .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
  );

  // behavioural reference model
  bit m_run, m_bsel, m_ext, m_tmr, m_ia, m_ib, m_s1, m_s2, m_s3;
  int m_sel, m_pre, m_cnt, m_a, m_b, m_ba, m_bb;

  function automatic int div_of(int s);
    int t[8] = '{1, 2, 4, 16, 64, 256, 1024, 4096};
    return t[s];
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_run = 0; m_bsel = 0; m_ext = 0; m_sel = 0; m_pre = 0; m_cnt = 0;
      m_tmr = 0; m_ia = 0; m_ib = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit tick, pst, ha, hb, ld;
      int na;
      int nb;
      tick = m_run && (m_ext ? (m_s2 && !m_s3) : ((m_pre % div_of(m_sel)) == div_of(m_sel) - 1));
      pst  = wr_i && addr_i == 0 && wdata_i[1];
      ha   = tick && !pst && m_cnt == m_a;
      hb   = tick && !pst && m_cnt == m_b;
      ld   = m_bsel && (pst || hb);
      if (!m_run) m_tmr = 0; else if (hb) m_tmr = 0; else if (ha) m_tmr = 1;
      m_ia = ha; m_ib = hb;
      if (pst || hb) m_cnt = 0; else if (tick) m_cnt = (m_cnt + 1) % 65536;
      na = m_a; nb = m_b;
      if (ld) begin na = m_ba; nb = m_bb; end
      if (wr_i && addr_i == 1) begin if (m_bsel) m_ba = wdata_i; else na = wdata_i; end
      if (wr_i && addr_i == 2) begin if (m_bsel) m_bb = wdata_i; else nb = wdata_i; end
      m_a = na; m_b = nb;
      m_pre = m_run ? (m_pre + 1) % 4096 : 0;
      if (wr_i && addr_i == 0) begin
        if (!m_run) begin m_ext = wdata_i[3]; m_sel = wdata_i[6:4]; end
        m_run = wdata_i[0]; m_bsel = wdata_i[2];
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = evt_i;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(logic [1:0] a);
    case (a)
      2'd0: return (m_sel << 4) | (int'(m_ext) << 3) | (int'(m_bsel) << 2) | int'(m_run);
      2'd1: return m_bsel ? m_ba : m_a;
      2'd2: return m_bsel ? m_bb : m_b;
      default: return m_cnt;
    endcase
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && cmp_en) begin
      check("R6 tmr_o", tmr_o, m_tmr);
      check("R5 irq_a_o", irq_a_o, m_ia);
      check("R5 irq_b_o", irq_b_o, m_ib);
      if (!wr_i)
        check(addr_i == 3 ? "R4 count" : addr_i == 0 ? "R3 ctrl" : "R7 compare",
              rdata_o, exp_rd(addr_i));
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk_i); #5; end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [15:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #5;
    wr_i = 1'b0; addr_i = rd_sel;
  endtask

  task automatic rd_check(logic [1:0] a, int exp, string tag);
    rd_sel = a; addr_i = a;
    @(negedge clk_i);
    check(tag, rdata_o, exp);
    @(posedge clk_i); #5;
  endtask

  task automatic pulse(int hi, int lo);
    evt_i = 1'b1; idle(hi);
    evt_i = 1'b0; idle(lo);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    cmp_en = 1'b1;
    // R1 reset state
    check("R1 tmr_o", tmr_o, 0);
    check("R1 irq_b_o", irq_b_o, 0);
    rd_check(2'd0, 0, "R1 ctrl");
    rd_check(2'd3, 0, "R1 count");
    rd_sel = 2'd0; addr_i = 2'd0;
    wr_reg(2'd1, 16'd3);
    wr_reg(2'd2, 16'd9);
    wr_reg(2'd0, 16'h0004);
    wr_reg(2'd1, 16'd3);
    wr_reg(2'd2, 16'd9);
    wr_reg(2'd0, 16'h0000);

    // R4 R5 R6 basic period at /1
    wr_reg(2'd0, 16'h0001);
    rd_sel = 2'd3; addr_i = 2'd3;
    idle(40);

    // R3 source/divider frozen while running
    wr_reg(2'd0, 16'h0039);
    rd_check(2'd0, 16'h0001, "R3 frozen");
    wr_reg(2'd0, 16'h0002);
    wr_reg(2'd0, 16'h0020);
    wr_reg(2'd0, 16'h0021);
    rd_check(2'd0, 16'h0021, "R3 stopped write");
    rd_sel = 2'd3; addr_i = 2'd3;
    idle(60);

    // R2 divider period
    for (int s = 0; s < 8; s++) begin
      int n;
      wr_reg(2'd0, 16'h0002);
      wr_reg(2'd1, 16'd0);
      wr_reg(2'd2, 16'd1);
      wr_reg(2'd0, 16'(s << 4));
      wr_reg(2'd0, 16'((s << 4) | 1));
      do @(negedge clk_i); while (!irq_b_o);
      n = 0;
      do begin @(negedge clk_i); n++; end while (!irq_b_o);
      check("R2 period", n, 2 * div_of(s));
      @(posedge clk_i); #5;
    end

    // R6 A==B keeps output low, then wide duty
    wr_reg(2'd0, 16'h0002);
    wr_reg(2'd1, 16'd5);
    wr_reg(2'd2, 16'd5);
    wr_reg(2'd0, 16'h0001);
    idle(30);
    check("R6 A==B low", tmr_o, 0);
    wr_reg(2'd0, 16'h0002);
    wr_reg(2'd1, 16'd2);
    wr_reg(2'd2, 16'd6);
    wr_reg(2'd0, 16'h0001);
    idle(30);
    wr_reg(2'd0, 16'h0000);
    idle(2);
    check("R6 stopped low", tmr_o, 0);

    // R7 R8 buffered update on match B
    wr_reg(2'd0, 16'h0002);
    wr_reg(2'd1, 16'd5);
    wr_reg(2'd2, 16'd5);
    wr_reg(2'd0, 16'h0004);
    wr_reg(2'd1, 16'd7);
    wr_reg(2'd2, 16'd20);
    rd_check(2'd1, 7, "R7 buffer read");
    rd_sel = 2'd3; addr_i = 2'd3;
    wr_reg(2'd0, 16'h0005);
    idle(50);
    wr_reg(2'd0, 16'h0001);
    rd_check(2'd1, 7, "R8 A loaded on match B");
    rd_check(2'd2, 20, "R8 B loaded on match B");
    // R8 load on preset
    wr_reg(2'd0, 16'h0004);
    wr_reg(2'd1, 16'd11);
    wr_reg(2'd0, 16'h0006);
    wr_reg(2'd0, 16'h0000);
    rd_check(2'd1, 11, "R8 A loaded on preset");

    // R9 preset mid-run
    wr_reg(2'd0, 16'h0001);
    rd_sel = 2'd3; addr_i = 2'd3;
    idle(7);
    wr_reg(2'd0, 16'h0003);
    rd_check(2'd3, 0, "R9 count zero");
    rd_check(2'd0, 16'h0001, "R9 self clear");
    rd_sel = 2'd3; addr_i = 2'd3;
    idle(10);

    // R10 external events
    wr_reg(2'd0, 16'h0002);
    wr_reg(2'd1, 16'd2);
    wr_reg(2'd2, 16'd4);
    wr_reg(2'd0, 16'h0008);
    wr_reg(2'd0, 16'h0009);
    rd_sel = 2'd3; addr_i = 2'd3;
    idle(4);
    for (int i = 0; i < 3; i++) pulse(2, 2);
    idle(4);
    rd_check(2'd3, 3, "R10 three events");
    for (int i = 0; i < 10; i++) pulse(2, 2);
    for (int i = 0; i < 6; i++) pulse(1, 1);
    idle(4);
    wr_reg(2'd0, 16'h0000);
    for (int i = 0; i < 4; i++) pulse(1, 2);
    idle(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule